// File: doc/BRIEF.md
# Absence-Free Reaction Trigger Wrapper

This block lets a small synchronous reaction table run from three asynchronous Boolean input channels. The design never needs to send a message to signal that an input is absent. Each input channel delivers a value over a valid/ready handshake into a one-entry head slot. The clock edge is the activation. At every edge the wrapper compares the values held in the slots against three guarded reactions and fires the one whose guard is met. Firing emits a one-cycle event on that reaction's output and empties only the slots that the reaction reads.

No reaction ever depends on an input being missing. Each guard needs its two inputs present with particular values. Any two guards share one input and require opposite values on it, so at most one reaction can be enabled at a time. The result is therefore independent of the order in which inputs arrive. A value that is left unused stays in its slot and is used at a later activation.

Back-pressure rules: an input's ready is high exactly when its slot is empty. A transfer happens on an edge where valid and ready are both high. While the slot is full, valid and data on that channel are ignored. The outputs have no ready. Each is a single-cycle valid pulse that the receiver must take.

Top module: `react_exec_wrap`

## Requirements
- R1: Each input's ready is high exactly when its slot is empty. On an edge with valid and ready both high, the slot stores the data bit and ready drops in the next cycle.
- R2: A full slot keeps its value unchanged until a fired reaction consumes it. Valid and data offered while the slot is full have no effect.
- R3: When slots A and B both hold 1, reaction one fires and o1_valid pulses.
- R4: When slots B and C both hold 0, reaction two fires and o2_valid pulses.
- R5: When slot A holds 0 and slot C holds 1, reaction three fires and o3_valid pulses.
- R6: A reaction fires at the first edge where all of its inputs are held. If its last input is captured at edge k, its output is high in the cycle after edge k+1.
- R7: When no guard is met, nothing is consumed and no output pulses. The held slots stay full, so their ready stays low.
- R8: Firing empties only the slots of that reaction's two inputs. The third slot, if full, stays full.
- R9: At most one output is high in any cycle. Each pulse lasts one cycle, and no output is high in the cycle after a pulse.
- R10: A synchronous active-high reset empties all slots (all ready high) and clears all outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every rising edge is an activation |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Channel A offers a value |
| a_data | input | 1 | Channel A Boolean value |
| a_ready | output | 1 | Channel A slot empty |
| b_valid | input | 1 | Channel B offers a value |
| b_data | input | 1 | Channel B Boolean value |
| b_ready | output | 1 | Channel B slot empty |
| c_valid | input | 1 | Channel C offers a value |
| c_data | input | 1 | Channel C Boolean value |
| c_ready | output | 1 | Channel C slot empty |
| o1_valid | output | 1 | Pulse: reaction one (A=1, B=1) fired |
| o2_valid | output | 1 | Pulse: reaction two (B=0, C=0) fired |
| o3_valid | output | 1 | Pulse: reaction three (A=0, C=1) fired |

## Verification
A transfer on edge k makes that channel's ready low from the cycle after edge k. A reaction whose last input arrives at edge k pulses its output in the cycle after edge k+1, and its slots report ready again in that same cycle. Inputs change only on falling edges. The bench compares every output on each falling edge against a queue-free behavioural model that updates on rising edges, so each comparison falls exactly one half cycle after the edge that produced the result. The directed scenarios also check these exact cycles explicitly, including the cycle before a pulse and the cycle after it.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int NUM_CH = 3;   // input channels A, B, C at bits 0, 1, 2
  localparam int NUM_RX = 3;   // non-stuttering reactions
  localparam int DATA_W = 1;   // Boolean messages

  typedef struct packed {
    logic [NUM_CH-1:0] need;   // inputs the guard reads
    logic [NUM_CH-1:0] want;   // required values on those inputs
  } rule_t;

  function automatic rule_t rule_of(input int k);
    rule_t r;
    case (k)
      0:       begin r.need = 3'b011; r.want = 3'b011; end  // A=1,B=1
      1:       begin r.need = 3'b110; r.want = 3'b000; end  // B=0,C=0
      default: begin r.need = 3'b101; r.want = 3'b100; end  // A=0,C=1
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rxw_head_slot.sv
module rxw_head_slot #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         consume,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (consume) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end
  end

  assign in_ready = !full;

  // R1: a handshake fills the slot with the offered value
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> full && data == $past(in_data));

  // R2: a held value is kept until consumed
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    full && !consume |=> full && $stable(data));

  // R8: only a full slot can be consumed
  a_r8_consume_full: assert property (@(posedge clk) disable iff (rst)
    consume |-> full);
endmodule

// File: rtl/rxw_react_sel.sv
module rxw_react_sel
  import rxw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] full,
  input  logic [NUM_CH-1:0] val,
  output logic [NUM_RX-1:0] fire,
  output logic [NUM_CH-1:0] consume
);
  logic [NUM_RX-1:0] hit;

  generate
    for (genvar k = 0; k < NUM_RX; k++) begin : g_rule
      localparam rule_t RL = rule_of(k);
      assign hit[k] = ((full & RL.need) == RL.need) &&
                      ((val & RL.need) == RL.want);
    end
  endgenerate

  always_comb begin
    logic taken;
    taken   = 1'b0;
    fire    = '0;
    consume = '0;
    for (int k = 0; k < NUM_RX; k++) begin
      if (hit[k] && !taken) begin
        taken   = 1'b1;
        fire[k] = 1'b1;
        consume = rule_of(k).need;
      end
    end
  end

  // R9: guards are pairwise exclusive, never two enabled together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  // R8: a firing reaction takes exactly two slots
  a_r8_two_taken: assert property (@(posedge clk) disable iff (rst)
    (|fire) |-> $countones(consume) == 2);
endmodule

// File: rtl/rxw_emit_reg.sv
module rxw_emit_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] fire,
  output logic [N-1:0] out_valid
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= '0;
    else     out_valid <= fire;
  end

  // R9: a pulse lasts one cycle and is followed by a quiet cycle
  a_r9_gap: assert property (@(posedge clk) disable iff (rst)
    (|out_valid) |=> out_valid == '0);

  // R9: never two outputs together
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));
endmodule

// File: rtl/react_exec_wrap.sv
module react_exec_wrap
  import rxw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_valid,
  input  logic a_data,
  output logic a_ready,
  input  logic b_valid,
  input  logic b_data,
  output logic b_ready,
  input  logic c_valid,
  input  logic c_data,
  output logic c_ready,
  output logic o1_valid,
  output logic o2_valid,
  output logic o3_valid
);
  logic [NUM_CH-1:0] ch_valid, ch_data, ch_ready;
  logic [NUM_CH-1:0] hd_full, hd_val, hd_take;
  logic [NUM_RX-1:0] rx_fire, rx_out;

  assign ch_valid = {c_valid, b_valid, a_valid};
  assign ch_data  = {c_data, b_data, a_data};
  assign {c_ready, b_ready, a_ready} = ch_ready;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
      rxw_head_slot #(.W(DATA_W)) slot_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (ch_valid[i]),
        .in_data  (ch_data[i]),
        .in_ready (ch_ready[i]),
        .consume  (hd_take[i]),
        .full     (hd_full[i]),
        .data     (hd_val[i])
      );
    end
  endgenerate

  rxw_react_sel sel_i (
    .clk     (clk),
    .rst     (rst),
    .full    (hd_full),
    .val     (hd_val),
    .fire    (rx_fire),
    .consume (hd_take)
  );

  rxw_emit_reg #(.N(NUM_RX)) emit_i (
    .clk       (clk),
    .rst       (rst),
    .fire      (rx_fire),
    .out_valid (rx_out)
  );

  assign {o3_valid, o2_valid, o1_valid} = rx_out;

  // R3: A=1 and B=1 held -> o1 next cycle, A and B freed
  a_r3_o1: assert property (@(posedge clk) disable iff (rst)
    hd_full[0] && hd_full[1] && hd_val[0] && hd_val[1]
    |=> o1_valid && a_ready && b_ready);

  // R4: B=0 and C=0 held -> o2 next cycle
  a_r4_o2: assert property (@(posedge clk) disable iff (rst)
    hd_full[1] && hd_full[2] && !hd_val[1] && !hd_val[2]
    |=> o2_valid && b_ready && c_ready);

  // R5: A=0 and C=1 held -> o3 next cycle
  a_r5_o3: assert property (@(posedge clk) disable iff (rst)
    hd_full[0] && hd_full[2] && !hd_val[0] && hd_val[2]
    |=> o3_valid && a_ready && c_ready);

  // R7: without a pulse, no held slot was freed
  a_r7_stutter: assert property (@(posedge clk) disable iff (rst)
    !(|rx_fire) |=> (ch_ready & $past(hd_full)) == '0);

  // R10: reset empties the slots and silences the outputs
  a_r10_reset: assert property (@(posedge clk)
    rst |=> a_ready && b_ready && c_ready && !o1_valid && !o2_valid && !o3_valid);
endmodule

// File: tb/react_exec_wrap_tb_top.sv
module react_exec_wrap_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic av = 0, ad = 0, bv = 0, bd = 0, cv = 0, cd = 0;
  logic a_ready, b_ready, c_ready, o1_valid, o2_valid, o3_valid;

  int total = 0;
  int bad = 0;
  int ncyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  react_exec_wrap dut_i (
    .clk(clk), .rst(rst),
    .a_valid(av), .a_data(ad), .a_ready(a_ready),
    .b_valid(bv), .b_data(bd), .b_ready(b_ready),
    .c_valid(cv), .c_data(cd), .c_ready(c_ready),
    .o1_valid(o1_valid), .o2_valid(o2_valid), .o3_valid(o3_valid)
  );

  // behavioural reference: slot occupancy and values, last emitted events
  bit mfull [3];
  bit mval  [3];
  bit mout  [3];

  always @(posedge clk) begin
    bit was_full [3];
    bit offer [3];
    bit odat [3];
    offer = '{av, bv, cv};
    odat  = '{ad, bd, cd};
    ncyc++;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin mfull[i] = 0; mout[i] = 0; end
    end else begin
      for (int i = 0; i < 3; i++) begin was_full[i] = mfull[i]; mout[i] = 0; end
      if (mfull[0] && mfull[1] && mval[0] && mval[1]) begin
        mout[0] = 1; mfull[0] = 0; mfull[1] = 0;
      end else if (mfull[1] && mfull[2] && !mval[1] && !mval[2]) begin
        mout[1] = 1; mfull[1] = 0; mfull[2] = 0;
      end else if (mfull[0] && mfull[2] && !mval[0] && mval[2]) begin
        mout[2] = 1; mfull[0] = 0; mfull[2] = 0;
      end
      for (int i = 0; i < 3; i++)
        if (offer[i] && !was_full[i]) begin mfull[i] = 1; mval[i] = odat[i]; end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, ncyc, act, exp);
    end
  endtask

  // per-cycle comparison against the model, half a cycle after each edge
  always @(negedge clk) begin
    if (ncyc >= 2 && !finished) begin
      chk("R1 a_ready", a_ready, !mfull[0]);
      chk("R1 b_ready", b_ready, !mfull[1]);
      chk("R1 c_ready", c_ready, !mfull[2]);
      chk("R3 o1_valid", o1_valid, mout[0]);
      chk("R4 o2_valid", o2_valid, mout[1]);
      chk("R5 o3_valid", o5_sel(), mout[2]);
      chk("R9 at most one output", $countones({o1_valid, o2_valid, o3_valid}) <= 1, 1'b1);
    end
  end

  function automatic logic o5_sel();
    return o3_valid;
  endfunction

  // drive one cycle of offers; v/d bit 0 = A, bit 1 = B, bit 2 = C
  task automatic put(input logic [2:0] v, input logic [2:0] d);
    @(negedge clk);
    {cv, bv, av} = v;
    {cd, bd, ad} = d;
  endtask

  task automatic idle();
    put(3'b000, 3'b000);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset a_ready", a_ready, 1'b1);
    chk("R10 reset b_ready", b_ready, 1'b1);
    chk("R10 reset c_ready", c_ready, 1'b1);
    chk("R10 reset outputs", o1_valid | o2_valid | o3_valid, 1'b0);
    rst = 1'b0;

    // R1/R2/R6: A=1 held, a conflicting A=0 ignored, then B=1 -> O1
    put(3'b001, 3'b001);
    idle();
    chk("R1 a_ready low when full", a_ready, 1'b0);
    chk("R7 no output with A alone", o1_valid | o2_valid | o3_valid, 1'b0);
    put(3'b001, 3'b000);
    put(3'b010, 3'b010);
    idle();
    chk("R6 no early o1", o1_valid, 1'b0);
    idle();
    chk("R2 R6 o1 from held A=1", o1_valid, 1'b1);
    chk("R3 a freed", a_ready, 1'b1);
    chk("R3 b freed", b_ready, 1'b1);
    idle();
    chk("R9 o1 single pulse", o1_valid, 1'b0);

    // R8/R4/R5: A=0,B=0,C=0 together -> O2 keeps A; then C=1 -> O3
    put(3'b111, 3'b000);
    idle();
    idle();
    chk("R4 o2 fires", o2_valid, 1'b1);
    chk("R8 a kept", a_ready, 1'b0);
    chk("R8 c freed", c_ready, 1'b1);
    put(3'b100, 3'b100);
    idle();
    idle();
    chk("R5 o3 fires", o3_valid, 1'b1);
    chk("R5 a freed", a_ready, 1'b1);

    // R7: B=1, C=1 only -> stutter; then A=1 -> O1 keeps C; then A=0 -> O3
    put(3'b110, 3'b110);
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R7 stutter no output", o1_valid | o2_valid | o3_valid, 1'b0);
      chk("R7 b held", b_ready, 1'b0);
      chk("R7 c held", c_ready, 1'b0);
    end
    put(3'b001, 3'b001);
    idle();
    idle();
    chk("R3 o1 after late A", o1_valid, 1'b1);
    chk("R8 c kept across O1", c_ready, 1'b0);
    put(3'b001, 3'b000);
    idle();
    idle();
    chk("R5 o3 with carried C", o3_valid, 1'b1);

    // R10: reset while a slot is full
    put(3'b001, 3'b001);
    idle();
    chk("R1 a full before reset", a_ready, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 a emptied", a_ready, 1'b1);
    chk("R10 outputs clear", o1_valid | o2_valid | o3_valid, 1'b0);

    // random traffic, compared every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      {cv, bv, av} = 3'($urandom);
      {cd, bd, ad} = 3'($urandom);
    end
    idle();
    idle();
    idle();
    finish_run();
  end
endmodule